// File: doc/BRIEF.md
# I2C SCL Generator with SDA Setup/Hold Placement

This block produces the SCL clock of an I2C master from the peripheral clock and decides the exact peripheral-clock cycle in which the SDA output takes its next bit. SCL is symmetric. Each phase lasts `(div_i + 1) * 2` peripheral clocks, so one SCL period is twice that length.

Within each period the SDA change is moved away from the SCL falling edge by two 6-bit delays: a hold delay and a setup delay. Each delay has an upper bound that depends on the divider. A delay above its bound is clamped to the bound, and an error flag is raised for that period. The SDA change therefore always stays inside the SCL low phase.

The divider, both delays and the next SDA bit are sampled only when SCL falls. A value written in the middle of a period first takes effect in the following period.

Top module: `scl_sda_timer`

## Requirements
- R1: During reset and until the first clock edge after reset is released, `scl_o` = 1, `sda_o` = 1 and `dly_err_o` = 0. The first clock edge after reset starts a period, and SCL falls on that edge.
- R2: Every SCL period has a low phase followed by a high phase. Each phase lasts exactly `half = (div + 1) * 2` clock cycles, where `div` is the divider sampled at the start of that period.
- R3: In each period, `sda_o` changes exactly `hold_eff + setup_eff` clock cycles after the edge on which SCL fell. A total of 0 means it changes on that same edge. It takes the value of `sda_bit_i` sampled on that falling edge.
- R4: The hold limit is `half - 9`, or 0 when `half` < 9. `hold_eff` is the hold setting, or the hold limit if the setting exceeds it. A hold setting above the limit raises the error flag.
- R5: The setup limit is `half - 1 - hold_eff`. `setup_eff` is the setup setting, or the setup limit if the setting exceeds it. A setup setting above the limit raises the error flag.
- R6: `dly_err_o` is constant over a whole period. It is 1 exactly when the settings sampled at the start of that period break R4 or R5, and 0 otherwise.
- R7: Changes to `div_i`, `hold_dly_i`, `setup_dly_i` or `sda_bit_i` after SCL has fallen have no effect on the current period.
- R8: `sda_o` never changes while `scl_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | Clock divider; each SCL phase is (div_i+1)*2 cycles |
| hold_dly_i | input | 6 | Hold delay in clock cycles |
| setup_dly_i | input | 6 | Setup delay in clock cycles |
| sda_bit_i | input | 1 | Next bit to place on SDA |
| scl_o | output | 1 | Generated SCL |
| sda_o | output | 1 | SDA, changed at the programmed position |
| dly_err_o | output | 1 | Delay setting exceeded its limit in this period |

## Verification
The bench targets the boundary between a legal delay and a clamped one. This includes hold exactly at `half - 9` against one above it, and setup exactly filling the rest of the low phase against one cycle more. A design with an off-by-one limit would either flag a legal setting or let SDA move while SCL is high.

The smallest divider is tested, where the hold limit collapses to 0. A design that subtracts without a floor would wrap and accept huge delays. The largest divider is tested to catch counter overflow.

Every input is scrambled right after SCL falls. A design that samples its settings anywhere but the falling edge would shift the SDA change or drive the wrong bit.

// File: rtl/scl_dly_pkg.sv
package scl_dly_pkg;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned DLY_W   = 6;
  localparam int unsigned HOLD_MARGIN = 9;
endpackage

// File: rtl/scl_dly_cfg.sv
module scl_dly_cfg #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DLY_W = 6,
  parameter int unsigned MARGIN = 9,
  localparam int unsigned W = DIV_W + 2
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] hold_i,
  input  logic [DLY_W-1:0] setup_i,
  output logic [W-1:0]     half_o,
  output logic [W-1:0]     pos_o,
  output logic             err_o
);
  logic [W-1:0] hold_w, setup_w, hold_lim, setup_lim, hold_eff, setup_eff;

  always_comb begin
    hold_w   = W'(hold_i);
    setup_w  = W'(setup_i);
    half_o   = (W'(div_i) + W'(1)) << 1;
    hold_lim = (half_o >= W'(MARGIN)) ? half_o - W'(MARGIN) : '0;
    hold_eff = (hold_w > hold_lim) ? hold_lim : hold_w;
    // setup may only fill what hold leaves of the low phase
    setup_lim = half_o - W'(1) - hold_eff;
    setup_eff = (setup_w > setup_lim) ? setup_lim : setup_w;
    pos_o     = hold_eff + setup_eff;
    err_o     = (hold_w > hold_lim) || (setup_w > setup_lim);
  end
endmodule

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] half_d_i,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] half_o,
  output logic         scl_o
);
  logic         run_q;
  logic [W-1:0] cnt_q, half_q, last;

  assign last   = (half_q << 1) - W'(1);
  assign wrap_o = !run_q || (cnt_q == last);
  assign cnt_o  = cnt_q;
  assign half_o = half_q;
  assign scl_o  = !run_q || (cnt_q >= half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= W'(2);
    end else if (wrap_o) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      half_q <= half_d_i;
    end else begin
      cnt_q  <= cnt_q + W'(1);
    end
  end

  assert_rise_at_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) |-> (cnt_q == half_q));
  assert_fall_at_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> (cnt_q == '0));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= last));
endmodule

// File: rtl/sda_place.sv
module sda_place #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] half_i,
  input  logic         scl_i,
  input  logic [W-1:0] pos_d_i,
  input  logic         err_d_i,
  input  logic         bit_i,
  output logic         sda_o,
  output logic         err_o
);
  logic [W-1:0] pos_q;
  logic         bit_q, sda_q, err_q;

  assign sda_o = sda_q;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      bit_q <= 1'b1;
      sda_q <= 1'b1;
      err_q <= 1'b0;
    end else if (wrap_i) begin
      pos_q <= pos_d_i;
      bit_q <= bit_i;
      err_q <= err_d_i;
      if (pos_d_i == '0) sda_q <= bit_i;
    end else if (cnt_i + W'(1) == pos_q) begin
      sda_q <= bit_q;
    end
  end

  assert_pos_in_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |-> (pos_q < half_i));
  assert_sda_quiet_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_o) |-> !scl_i);
  assert_err_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && $past(!wrap_i)) |-> $stable(err_o));
endmodule

// File: rtl/scl_sda_timer.sv
module scl_sda_timer
  import scl_dly_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned LW = DLY_W,
  localparam int unsigned W = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  input  logic [LW-1:0] hold_dly_i,
  input  logic [LW-1:0] setup_dly_i,
  input  logic          sda_bit_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          dly_err_o
);
  logic [W-1:0] half_d, pos_d, cnt, half_q;
  logic         err_d, wrap;

  scl_dly_cfg #(.DIV_W(DW), .DLY_W(LW), .MARGIN(HOLD_MARGIN)) u_cfg (
    .div_i(div_i), .hold_i(hold_dly_i), .setup_i(setup_dly_i),
    .half_o(half_d), .pos_o(pos_d), .err_o(err_d)
  );

  scl_gen #(.W(W)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_d_i(half_d),
    .wrap_o(wrap), .cnt_o(cnt), .half_o(half_q), .scl_o(scl_o)
  );

  sda_place #(.W(W)) u_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .cnt_i(cnt),
    .half_i(half_q), .scl_i(scl_o), .pos_d_i(pos_d), .err_d_i(err_d),
    .bit_i(sda_bit_i), .sda_o(sda_o), .err_o(dly_err_o)
  );
endmodule

// File: tb/scl_sda_timer_tb.sv
module scl_sda_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic [5:0] hold_dly_i = '0, setup_dly_i = '0;
  logic       sda_bit_i = 1'b1;
  logic       scl_o, sda_o, dly_err_o;
  int         checks = 0, errors = 0, cyc = 0;

  scl_sda_timer u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int f_half(int d); return (d + 1) * 2; endfunction
  function automatic int f_hlim(int d); return f_half(d) >= 9 ? f_half(d) - 9 : 0; endfunction
  function automatic int f_heff(int d, int h); return h > f_hlim(d) ? f_hlim(d) : h; endfunction
  function automatic int f_slim(int d, int h); return f_half(d) - 1 - f_heff(d, h); endfunction
  function automatic int f_pos(int d, int h, int s);
    return f_heff(d, h) + (s > f_slim(d, h) ? f_slim(d, h) : s);
  endfunction
  function automatic bit f_err(int d, int h, int s);
    return (h > f_hlim(d)) || (s > f_slim(d, h));
  endfunction

  task automatic trial(input int d, input int h, input int s);
    int  half, pos, k, chg, hi;
    bit  eb, old, val, e, err_bad, sda_hi_bad;
    half = f_half(d); pos = f_pos(d, h, s); e = f_err(d, h, s);
    @(negedge clk_i);
    while (!scl_o) @(negedge clk_i);
    div_i = 8'(d); hold_dly_i = 6'(h); setup_dly_i = 6'(s);
    eb = ~sda_o; sda_bit_i = eb;
    old = sda_o;
    while (scl_o) begin old = sda_o; @(negedge clk_i); end
    // R7: scramble everything right after the falling edge
    div_i = 8'($urandom_range(0, 40)); hold_dly_i = 6'($urandom);
    setup_dly_i = 6'($urandom); sda_bit_i = old;
    k = 0; chg = -1; val = old; err_bad = 0;
    while (!scl_o) begin
      if (chg < 0 && sda_o != old) begin chg = k; val = sda_o; end
      if (dly_err_o != e) err_bad = 1;
      k++;
      @(negedge clk_i);
    end
    check(k == half, "R2 low phase", k, half);
    check(chg == pos, "R3 sda position", chg, pos);
    check(val == eb, "R7 sda value sampled at fall", int'(val), int'(eb));
    hi = 0; sda_hi_bad = 0; old = sda_o;
    while (scl_o) begin
      if (sda_o != old) sda_hi_bad = 1;
      if (dly_err_o != e) err_bad = 1;
      hi++;
      @(negedge clk_i);
    end
    check(hi == half, "R2 high phase", hi, half);
    check(!sda_hi_bad, "R8 sda quiet while scl high", int'(sda_hi_bad), 0);
    check(!err_bad, e ? "R4 R5 R6 error flag set" : "R6 error flag clear", int'(!e), int'(e));
  endtask

  initial begin
    wait (cyc == WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(scl_o == 1'b1, "R1 reset scl", int'(scl_o), 1);
    check(sda_o == 1'b1, "R1 reset sda", int'(sda_o), 1);
    check(dly_err_o == 1'b0, "R1 reset err", int'(dly_err_o), 0);
    div_i = 8'd3;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(scl_o == 1'b0, "R1 first edge starts period", int'(scl_o), 0);
    // directed: 60-cycle phases
    trial(29, 61, 0);   // R4 hold above limit
    trial(29, 51, 0);   // R4 hold at limit
    trial(29, 52, 0);   // R4 one above
    trial(29, 51, 8);   // R5 setup at limit
    trial(29, 51, 9);   // R5 one above
    trial(29, 0, 0);    // R3 change on falling edge
    trial(0, 5, 0);     // R4 limit floors at 0
    trial(0, 0, 1);     // R5 setup fills low phase
    trial(0, 0, 2);     // R5 one above
    trial(255, 63, 63); // R2 largest divider
    for (int i = 0; i < 50; i++)
      trial($urandom_range(0, 40), $urandom_range(0, 63), $urandom_range(0, 63));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule